// File: doc/BRIEF.md
# TDM Timeslot Pseudorandom Pattern Inserter

This block sits on one serial TDM output stream and replaces chosen 8-bit timeslots with a 2^15-1 pseudorandom test sequence (feedback polynomial x^15 + x^14 + 1). All other timeslots carry the switched byte unchanged. A far-end checker can then measure bit errors over a run of consecutive timeslots that starts at any channel and lasts from one channel to a whole frame.

Timing comes from two strobes. `chan_strobe` marks the start of each channel, and `frame_sync`, raised together with it, marks channel 0. On each channel strobe a connection-memory lookup supplies a message-mode bit and a 2-bit control field. The channel carries the pattern only when the global `tx_enable` is set, the mode bit is 1 and the control field is binary 10. The generator advances only on bits that it emits. Because it holds its state through every other channel, the sequence runs on without a gap from one selected channel to the next.

A per-channel state machine has three named states. ST_IDLE means no channel is active. ST_PASS shifts out a switched byte. ST_GEN emits generator bits. The transitions are as follows. A strobe with the channel selected goes to ST_GEN (from any state). A strobe with the channel not selected goes to ST_PASS (from any state). After the eighth bit with no new strobe, ST_PASS or ST_GEN returns to ST_IDLE. In every other case the state holds.

Top module: `tdm_prbs_inserter`

## Requirements
- R1: After reset, `out_valid`, `out_prbs`, `ser_out`, `ser_is_prbs`, `out_byte` and `chan_num` are all 0.
- R2: A channel is a pattern channel only if, on its strobe, `tx_enable`=1, `cm_msg_mode`=1 and `cm_ctrl`=2'b10. Every other channel outputs `sw_byte`, as captured on its strobe, unchanged, with `out_prbs`=0.
- R3: Each pattern bit is s[14] XOR s[13] of the 15-bit generator state. That bit is also shifted into s[0]. The eight bits of a channel fill the byte MSB first, and they appear one per cycle on `ser_out`, with `ser_is_prbs`=1, in the eight cycles after the strobe.
- R4: While `tx_enable`=0 the generator is held at all ones. As a result, the first two pattern bytes after enable are 0x00 and 0x02.
- R5: The generator state changes only during bits of pattern channels. A pattern therefore continues across pass channels, and it continues over a run of up to a whole frame of consecutive pattern channels.
- R6: The generator state is never all zeros.
- R7: `out_valid` is a one-cycle pulse in the cycle after a channel's eighth bit. It presents `out_byte` together with `out_prbs`, which is 1 for a pattern channel.
- R8: On each strobe `chan_num` becomes 0 if `frame_sync`=1. Otherwise it increments and wraps to 0 after channel (32 << `rate_sel`) - 1, where `rate_sel` 0..3 means 32, 64, 128 or 256 channels per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Global pattern-generator enable |
| rate_sel | input | 2 | Stream rate: channels per frame = 32 << rate_sel |
| frame_sync | input | 1 | With chan_strobe, marks channel 0 |
| chan_strobe | input | 1 | First cycle of a channel; captures selection and data |
| cm_msg_mode | input | 1 | Connection-entry message-mode bit |
| cm_ctrl | input | 2 | Connection-entry control field (2'b10 selects pattern) |
| sw_byte | input | 8 | Switched byte for this channel |
| ser_out | output | 1 | Serial channel bit, MSB first |
| ser_is_prbs | output | 1 | Current serial bit is a pattern bit |
| out_byte | output | 8 | Completed channel byte |
| out_valid | output | 1 | One-cycle strobe for out_byte |
| out_prbs | output | 1 | Completed byte was a pattern byte |
| chan_num | output | 8 | Number of the channel last strobed |

## Verification
Some properties are checked on every cycle. The generator is never all zeros. It is forced to all ones while disabled. It stays frozen whenever the state machine is not emitting pattern bits. Byte strobes never come in back-to-back cycles, and the channel number never goes past the end of the frame after a strobe.

Other behaviour can only be shown by the bench's scenarios, which compare every byte and every serial bit with an independent model of the sequence. These cover the exact sequence values (including the 0x00, 0x02 start after enable), the decoding of the mode bit and control field, continuity across pass channels, a full frame of pattern channels, and channel wrap at two rates.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_GEN  = 2'd2
    } ch_state_t;

    localparam int          PRBS_LEN   = 15;
    localparam int          PRBS_TAP_A = 14;
    localparam int          PRBS_TAP_B = 13;
    localparam int          BASE_CHANS = 32;
    localparam logic [1:0]  SEL_CODE   = 2'b10;
endpackage

// File: rtl/prbs_core.sv
module prbs_core #(
    parameter int W     = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         advance,
    output logic [W-1:0] state,
    output logic         bit_out
);
    logic [W-1:0] st_q;

    assign bit_out = st_q[TAP_A] ^ st_q[TAP_B];
    assign state   = st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st_q <= '1;
        else if (seed)    st_q <= '1;
        else if (advance) st_q <= {st_q[W-2:0], bit_out};
    end

    // Generator never locks up in the all-zero state
    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        |st_q);
endmodule

// File: rtl/chan_counter.sv
module chan_counter #(
    parameter int CNT_W      = 8,
    parameter int BASE_CHANS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             frame_sync,
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] chan_num
);
    logic [CNT_W-1:0] last_chan;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        last_chan = CNT_W'((BASE_CHANS << rate_sel) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strobe) begin
            if (frame_sync || cnt_q >= last_chan) cnt_q <= '0;
            else                                  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign chan_num = cnt_q;

    // After a strobe the channel index lies inside the frame
    p_chan_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt_q <= $past(last_chan)));
endmodule

// File: rtl/tdm_prbs_inserter.sv
module tdm_prbs_inserter
    import tdm_prbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [1:0]        rate_sel,
    input  logic              frame_sync,
    input  logic              chan_strobe,
    input  logic              cm_msg_mode,
    input  logic [1:0]        cm_ctrl,
    input  logic [BYTE_W-1:0] sw_byte,
    output logic              ser_out,
    output logic              ser_is_prbs,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              out_prbs,
    output logic [CNT_W-1:0]  chan_num
);
    localparam int              BIT_W    = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    ch_state_t               state_q, state_d;
    logic [BIT_W-1:0]        bit_cnt_q;
    logic [BYTE_W-1:0]       pass_q;
    logic [BYTE_W-2:0]       acc_q;
    logic                    chan_sel;
    logic                    chan_done;
    logic [PRBS_LEN-1:0]     gen_state;
    logic                    gen_bit;

    assign chan_sel  = tx_enable && cm_msg_mode && (cm_ctrl == SEL_CODE);
    assign chan_done = (state_q != ST_IDLE) && (bit_cnt_q == LAST_BIT);

    prbs_core #(
        .W     (PRBS_LEN),
        .TAP_A (PRBS_TAP_A),
        .TAP_B (PRBS_TAP_B)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed    (!tx_enable),
        .advance (state_q == ST_GEN),
        .state   (gen_state),
        .bit_out (gen_bit)
    );

    chan_counter #(
        .CNT_W      (CNT_W),
        .BASE_CHANS (BASE_CHANS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (chan_strobe),
        .frame_sync (frame_sync),
        .rate_sel   (rate_sel),
        .chan_num   (chan_num)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (chan_strobe) state_d = chan_sel ? ST_GEN : ST_PASS;
            end
            ST_PASS, ST_GEN: begin
                if (chan_strobe)    state_d = chan_sel ? ST_GEN : ST_PASS;
                else if (chan_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Serial output per state
    always_comb begin
        ser_out     = 1'b0;
        ser_is_prbs = 1'b0;
        unique case (state_q)
            ST_IDLE: ser_out = 1'b0;
            ST_PASS: ser_out = pass_q[LAST_BIT - bit_cnt_q];
            ST_GEN: begin
                ser_out     = gen_bit;
                ser_is_prbs = 1'b1;
            end
            default: ser_out = 1'b0;
        endcase
    end

    // Bit counter, byte capture and byte assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            pass_q    <= '0;
            acc_q     <= '0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_prbs  <= 1'b0;
        end else begin
            out_valid <= chan_done;
            if (chan_done) begin
                out_byte <= {acc_q, ser_out};
                out_prbs <= (state_q == ST_GEN);
            end
            if (state_q != ST_IDLE) acc_q <= {acc_q[BYTE_W-3:0], ser_out};
            if (chan_strobe) begin
                bit_cnt_q <= '0;
                pass_q    <= sw_byte;
            end else if (state_q != ST_IDLE) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Generator is reseeded to all ones whenever disabled
    p_seed_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (&gen_state));

    // Generator holds outside pattern bits
    p_hold_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_GEN) && tx_enable |=> $stable(gen_state));

    // Byte strobe lasts one cycle and follows an active channel
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    p_valid_after_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q != ST_IDLE));

    // Pattern marker only comes from an enabled generator state
    p_prbs_needs_gen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_is_prbs |-> (state_q == ST_GEN));
endmodule

// File: tb/tdm_prbs_inserter_test.sv
module tdm_prbs_inserter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       frame_sync = 1'b0;
    logic       chan_strobe = 1'b0;
    logic       cm_msg_mode = 1'b0;
    logic [1:0] cm_ctrl = 2'b00;
    logic [7:0] sw_byte = 8'h00;
    logic       ser_out, ser_is_prbs, out_valid, out_prbs;
    logic [7:0] out_byte, chan_num;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic [14:0] m_lfsr = '1;
    int          exp_chan = 0;
    logic [7:0]  first_bytes[2];

    always #2.5 clk = ~clk;

    tdm_prbs_inserter uut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .rate_sel(rate_sel),
        .frame_sync(frame_sync), .chan_strobe(chan_strobe),
        .cm_msg_mode(cm_msg_mode), .cm_ctrl(cm_ctrl), .sw_byte(sw_byte),
        .ser_out(ser_out), .ser_is_prbs(ser_is_prbs), .out_byte(out_byte),
        .out_valid(out_valid), .out_prbs(out_prbs), .chan_num(chan_num)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design completes them
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected byte", int'(out_byte), 0);
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_prbs, out_byte} == e, t, int'({out_prbs, out_byte}), int'(e));
            end
        end
    end

    // Driver: one channel, called just after a falling edge
    task automatic send_chan(input bit fs, input bit mode, input logic [1:0] ctrl,
                             input logic [7:0] data, input string tag);
        logic [7:0] exp_b;
        logic       sel;
        logic       fb;
        bit         ser_ok;
        int         last;
        sel = tx_enable && mode && (ctrl == 2'b10);
        exp_b = data;
        if (sel) begin
            for (int i = 0; i < 8; i++) begin
                fb = m_lfsr[14] ^ m_lfsr[13];
                m_lfsr = {m_lfsr[13:0], fb};
                exp_b = {exp_b[6:0], fb};
            end
        end
        exp_q.push_back({sel, exp_b});
        tag_q.push_back(tag);
        last = (32 << rate_sel) - 1;
        exp_chan = (fs || exp_chan >= last) ? 0 : exp_chan + 1;
        frame_sync = fs; chan_strobe = 1'b1; cm_msg_mode = mode; cm_ctrl = ctrl; sw_byte = data;
        @(negedge clk);
        frame_sync = 1'b0; chan_strobe = 1'b0;
        check(int'(chan_num) == exp_chan, "R8 channel number", int'(chan_num), exp_chan);
        ser_ok = 1;
        for (int i = 7; i >= 0; i--) begin
            if (ser_out !== exp_b[i] || ser_is_prbs !== sel) ser_ok = 0;
            if (i > 0) @(negedge clk);
        end
        check(ser_ok, "R3 serial bits", int'(ser_ok), 1);
    endtask

    task automatic flush();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
    endtask

    // Computes the first pattern bytes from all ones, for the R4 start check
    task automatic model_first_two();
        logic [14:0] s;
        logic        fb;
        s = '1;
        for (int k = 0; k < 2; k++) begin
            first_bytes[k] = 8'h00;
            for (int i = 0; i < 8; i++) begin
                fb = s[14] ^ s[13];
                s = {s[13:0], fb};
                first_bytes[k] = {first_bytes[k][6:0], fb};
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({out_valid, out_prbs, ser_out, ser_is_prbs} == 4'b0, "R1 reset flags",
              int'({out_valid, out_prbs, ser_out, ser_is_prbs}), 0);
        check(out_byte == 8'h00 && chan_num == 8'h00, "R1 reset byte/channel",
              int'({out_byte, chan_num}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled generator passes even selected channels
        send_chan(1, 1, 2'b10, 8'hA5, "R2 disabled pass");
        send_chan(0, 1, 2'b10, 8'h3C, "R2 disabled pass");
        flush();

        // R4: enable, first two pattern bytes
        tx_enable = 1'b1;
        model_first_two();
        check(first_bytes[0] == 8'h00 && first_bytes[1] == 8'h02, "R4 model start",
              int'({first_bytes[0], first_bytes[1]}), 16'h0002);
        @(negedge clk);
        send_chan(1, 0, 2'b00, 8'h11, "R2 plain pass");
        send_chan(0, 1, 2'b10, 8'h22, "R4 first byte 0x00");
        send_chan(0, 1, 2'b10, 8'h33, "R4 second byte 0x02");
        // R2 decode: wrong control codes and mode bit pass data
        send_chan(0, 1, 2'b01, 8'h44, "R2 ctrl 01 pass");
        send_chan(0, 1, 2'b11, 8'h55, "R2 ctrl 11 pass");
        send_chan(0, 0, 2'b10, 8'h66, "R2 mode 0 pass");
        // R5 continuity after pass channels
        send_chan(0, 1, 2'b10, 8'h77, "R5 continue");
        send_chan(0, 1, 2'b10, 8'h88, "R5 continue");
        flush();

        // R8 wrap at 32 channels, no frame sync after channel 0
        rate_sel = 2'd0;
        send_chan(1, 0, 2'b00, 8'h00, "R8 rate0 pass");
        for (int c = 1; c < 34; c++) send_chan(0, 0, 2'b00, 8'(c), "R8 rate0 pass");
        flush();

        // R8 wrap at 64 channels
        rate_sel = 2'd1;
        send_chan(1, 0, 2'b00, 8'hF0, "R8 rate1 pass");
        for (int c = 1; c < 66; c++) send_chan(0, 0, 2'b00, 8'(c * 3), "R8 rate1 pass");
        flush();

        // R4: disable reseeds, re-enable starts at 0x00 again
        tx_enable = 1'b0; m_lfsr = '1;
        repeat (4) @(negedge clk);
        tx_enable = 1'b1;
        @(negedge clk);
        rate_sel = 2'd0;
        // R5: a whole frame of consecutive pattern channels
        send_chan(1, 1, 2'b10, 8'h9A, "R4 restart byte 0x00");
        for (int c = 1; c < 32; c++) send_chan(0, 1, 2'b10, 8'(c), "R5 full frame");
        // R5: pattern window starting mid-frame, then next frame
        send_chan(1, 0, 2'b00, 8'h5A, "R2 window pass");
        send_chan(0, 0, 2'b00, 8'hA5, "R2 window pass");
        send_chan(0, 1, 2'b10, 8'h01, "R5 window mid-frame");
        send_chan(0, 1, 2'b10, 8'h02, "R5 window mid-frame");
        flush();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule